// File: doc/BRIEF.md
# Burst-of-Two Quad-Data-Rate SRAM Controller

This block sits between a user and a static RAM that has separate read and write data ports. Each memory command moves two words. The user side has two independent request channels: a write channel that carries an address, two data words and two per-lane enable sets, and a read channel that carries an address. Each channel has a valid/ready handshake and a small queue. The memory side drives active-low read and write strobes, one address bus, active-low per-lane write masks and write data. It also takes back the read data bus.

Double-data-rate timing is modelled with a fast clock that runs at twice the memory interface rate. Each interface cycle is two fast cycles. The first is the rising-edge half (K half) and the second is the falling-edge half (/K half). The `mem_k` output shows which half is current. In the K half the address bus carries the read address, and the write data and masks carry the first write beat. In the /K half the bus carries the write address, and data and masks carry the second beat. A read and a write can start in the same interface cycle.

A phase machine has three states. PH_RESET is held while reset is asserted and goes to PH_KRISE on the first edge after release. PH_KRISE always goes to PH_KFALL. PH_KFALL always goes back to PH_KRISE, and on that transition the next read and write commands are loaded from the queue heads. The data width is 9, 18 or 36 bits, with one mask bit per 9-bit lane. Read data is captured a fixed number of interface cycles after the command and returned as an ordered pair with one valid pulse.

Top module: `qdr2_b2_ctrl`

## Requirements
- R1: While `rst_n` is low, `mem_r_n`, `mem_w_n` and every `mem_bw_n` bit are 1, `rsp_valid` is 0, and both `wr_ready` and `rd_ready` are 0.
- R2: A read drives `mem_r_n` low for exactly one K half plus the /K half that follows it. During that K half, `mem_addr` equals the read address.
- R3: A write drives `mem_w_n` low for one K half plus the following /K half. During that /K half, `mem_addr` equals the write address.
- R4: `mem_d` carries `wr_data0` in the K half of the write and `wr_data1` in the /K half.
- R5: Write enable bit i covers data bits 9i to 9i+8. `mem_bw_n[i]` is the inverse of `wr_en0[i]` in the K half and of `wr_en1[i]` in the /K half. All mask bits are 1 whenever `mem_w_n` is 1.
- R6: While both strobes stay high, `mem_addr` keeps its previous value.
- R7: If a read and a write are both queued when commands are loaded, both strobes go low in the same interface cycle.
- R8: Suppose a read's K half is fast cycle t and RD_LAT is the latency parameter. Then `mem_q` is sampled at the end of fast cycle t+2·RD_LAT (first word, `rsp_data0`) and at the end of t+2·RD_LAT+1 (second word, `rsp_data1`). `rsp_valid` is high for exactly one fast cycle, t+2·RD_LAT+2.
- R9: A ready signal is low while its queue holds QDEPTH requests. Requests on each channel reach the memory in the order they were accepted, and every accepted request completes.
- R10: `mem_k` is 0 in reset. It is 1 in the first fast cycle after release and then alternates every fast cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the interface rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write queue can accept |
| wr_addr | input | ADDR_W | Write burst address |
| wr_data0 | input | DATA_W | First write word |
| wr_data1 | input | DATA_W | Second write word |
| wr_en0 | input | DATA_W/9 | Lane enables for first word, active high |
| wr_en1 | input | DATA_W/9 | Lane enables for second word, active high |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read queue can accept |
| rd_addr | input | ADDR_W | Read burst address |
| rsp_valid | output | 1 | One-cycle pulse, read pair available |
| rsp_data0 | output | DATA_W | First returned word |
| rsp_data1 | output | DATA_W | Second returned word |
| mem_k | output | 1 | High during the K half |
| mem_r_n | output | 1 | Read strobe, active low |
| mem_w_n | output | 1 | Write strobe, active low |
| mem_addr | output | ADDR_W | Shared address bus |
| mem_bw_n | output | DATA_W/9 | Per-lane write masks, active low |
| mem_d | output | DATA_W | Write data |
| mem_q | input | DATA_W | Read data from memory |

## Verification
The bench includes a memory model that decodes the strobes in each half-cycle.

- **Half swap.** A controller that swapped the halves would put the write address in the K half or the second word in the first beat. The per-half checks of address, data and masks report this.
- **Per-beat masks.** Opposing masks on the two beats catch a design that reuses one mask set for both beats. They also catch a lane that is mapped to the wrong 9 bits.
- **Same-cycle issue.** A read and a write are queued together to show that both strobes fall in the same interface cycle.
- **Capture latency and order.** The exact fast-cycle count from read strobe to response pulse is checked, along with the order of the returned pair. A shifted capture pipeline or swapped words fail here.
- **Back-to-back bursts.** These fill the queues. A controller that dropped or reordered a request on backpressure fails the address order and data checks.

// File: rtl/qdr2_pkg.sv
package qdr2_pkg;

    // Bits per write-mask lane
    localparam int LANE_BITS = 9;

    // Fast-clock phase of the memory interface
    typedef enum logic [1:0] {
        PH_RESET = 2'd0,
        PH_KRISE = 2'd1,
        PH_KFALL = 2'd2
    } qdr_phase_e;

endpackage

// File: rtl/qdr2_req_fifo.sv
module qdr2_req_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = PW + 1;

    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) begin
                wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
            end
            if (pop) begin
                rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
            end
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            slots[wp] <= din;
        end
    end

    assign dout  = slots[rp];
    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);

endmodule

// File: rtl/qdr2_rd_capture.sv
module qdr2_rd_capture #(
    parameter int DATA_W = 36,
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [DATA_W-1:0] mem_q,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data0,
    output logic [DATA_W-1:0] rsp_data1
);

    // One bit per fast cycle since a read's K half
    localparam int PIPE  = 2 * RD_LAT + 1;
    localparam int TAP_A = 2 * RD_LAT - 1;
    localparam int TAP_B = 2 * RD_LAT;

    logic [PIPE-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe      <= '0;
            rsp_valid <= 1'b0;
            rsp_data0 <= '0;
            rsp_data1 <= '0;
        end else begin
            pipe      <= {pipe[PIPE-2:0], issue};
            rsp_valid <= pipe[TAP_B];
            if (pipe[TAP_A]) begin
                rsp_data0 <= mem_q;
            end
            if (pipe[TAP_B]) begin
                rsp_data1 <= mem_q;
            end
        end
    end

endmodule

// File: rtl/qdr2_b2_ctrl.sv
module qdr2_b2_ctrl #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 10,
    parameter int RD_LAT = 2,
    parameter int QDEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_valid,
    output logic                  wr_ready,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data0,
    input  logic [DATA_W-1:0]     wr_data1,
    input  logic [DATA_W/9-1:0]   wr_en0,
    input  logic [DATA_W/9-1:0]   wr_en1,
    input  logic                  rd_valid,
    output logic                  rd_ready,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_data0,
    output logic [DATA_W-1:0]     rsp_data1,
    output logic                  mem_k,
    output logic                  mem_r_n,
    output logic                  mem_w_n,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W/9-1:0]   mem_bw_n,
    output logic [DATA_W-1:0]     mem_d,
    input  logic [DATA_W-1:0]     mem_q
);

    import qdr2_pkg::*;

    localparam int LANES = DATA_W / LANE_BITS;
    localparam int WPKT  = ADDR_W + 2 * DATA_W + 2 * LANES;

    // Request queues
    logic              wr_push, wr_pop, wr_full, wr_empty;
    logic              rd_push, rd_pop, rd_full, rd_empty;
    logic [WPKT-1:0]   wr_din, wr_head;
    logic [ADDR_W-1:0] rd_head;

    assign wr_ready = rst_n & ~wr_full;
    assign rd_ready = rst_n & ~rd_full;
    assign wr_push  = wr_valid & wr_ready;
    assign rd_push  = rd_valid & rd_ready;
    assign wr_din   = {wr_addr, wr_data0, wr_data1, wr_en0, wr_en1};

    qdr2_req_fifo #(.W(WPKT), .DEPTH(QDEPTH)) u_wr_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_push),
        .din   (wr_din),
        .pop   (wr_pop),
        .dout  (wr_head),
        .full  (wr_full),
        .empty (wr_empty)
    );

    qdr2_req_fifo #(.W(ADDR_W), .DEPTH(QDEPTH)) u_rd_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rd_push),
        .din   (rd_addr),
        .pop   (rd_pop),
        .dout  (rd_head),
        .full  (rd_full),
        .empty (rd_empty)
    );

    // Phase machine
    qdr_phase_e ph_q, ph_d;

    always_comb begin
        unique case (ph_q)
            PH_RESET: ph_d = PH_KRISE;
            PH_KRISE: ph_d = PH_KFALL;
            PH_KFALL: ph_d = PH_KRISE;
            default:  ph_d = PH_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= PH_RESET;
        end else begin
            ph_q <= ph_d;
        end
    end

    // Commands are taken from the queues on every entry into the K half
    logic load_slot;
    assign load_slot = (ph_d == PH_KRISE);
    assign wr_pop    = load_slot & ~wr_empty;
    assign rd_pop    = load_slot & ~rd_empty;

    logic              cmd_wr_v, cmd_rd_v;
    logic [ADDR_W-1:0] cmd_wa, cmd_ra;
    logic [DATA_W-1:0] cmd_wd0, cmd_wd1;
    logic [LANES-1:0]  cmd_we0, cmd_we1;
    logic [ADDR_W-1:0] h_wa;
    logic [DATA_W-1:0] h_wd0, h_wd1;
    logic [LANES-1:0]  h_we0, h_we1;

    assign {h_wa, h_wd0, h_wd1, h_we0, h_we1} = wr_head;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_wr_v <= 1'b0;
            cmd_rd_v <= 1'b0;
            cmd_wa   <= '0;
            cmd_ra   <= '0;
            cmd_wd0  <= '0;
            cmd_wd1  <= '0;
            cmd_we0  <= '0;
            cmd_we1  <= '0;
        end else if (load_slot) begin
            cmd_wr_v <= ~wr_empty;
            cmd_rd_v <= ~rd_empty;
            if (!wr_empty) begin
                cmd_wa  <= h_wa;
                cmd_wd0 <= h_wd0;
                cmd_wd1 <= h_wd1;
                cmd_we0 <= h_we0;
                cmd_we1 <= h_we1;
            end
            if (!rd_empty) begin
                cmd_ra <= rd_head;
            end
        end
    end

    // Address hold register: the bus keeps its value when unused
    logic [ADDR_W-1:0] last_addr;
    logic [ADDR_W-1:0] addr_sel;
    logic [DATA_W-1:0] beat_d;
    logic [LANES-1:0]  beat_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_addr <= '0;
        end else begin
            last_addr <= addr_sel;
        end
    end

    // Output decode per phase
    always_comb begin
        mem_k    = 1'b0;
        mem_r_n  = 1'b1;
        mem_w_n  = 1'b1;
        addr_sel = last_addr;
        beat_d   = '0;
        beat_en  = '0;
        unique case (ph_q)
            PH_RESET: begin
                mem_k = 1'b0;
            end
            PH_KRISE: begin
                mem_k   = 1'b1;
                mem_r_n = ~cmd_rd_v;
                mem_w_n = ~cmd_wr_v;
                if (cmd_rd_v) begin
                    addr_sel = cmd_ra;
                end
                beat_d  = cmd_wd0;
                beat_en = cmd_we0;
            end
            PH_KFALL: begin
                mem_k   = 1'b0;
                mem_r_n = ~cmd_rd_v;
                mem_w_n = ~cmd_wr_v;
                if (cmd_wr_v) begin
                    addr_sel = cmd_wa;
                end
                beat_d  = cmd_wd1;
                beat_en = cmd_we1;
            end
            default: begin
                mem_k = 1'b0;
            end
        endcase
    end

    assign mem_addr = addr_sel;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mem_bw_n[g] = ~(beat_en[g] & ~mem_w_n);
        assign mem_d[g*LANE_BITS +: LANE_BITS] =
            mem_w_n ? '0 : beat_d[g*LANE_BITS +: LANE_BITS];
    end

    // Read return path
    logic rd_issue;
    assign rd_issue = (ph_q == PH_KRISE) & cmd_rd_v;

    qdr2_rd_capture #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (rd_issue),
        .mem_q     (mem_q),
        .rsp_valid (rsp_valid),
        .rsp_data0 (rsp_data0),
        .rsp_data1 (rsp_data1)
    );

endmodule

// File: rtl/qdr2_ctrl_checker.sv
module qdr2_ctrl_checker #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_k,
    input logic              mem_r_n,
    input logic              mem_w_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]  mem_bw_n,
    input logic              rsp_valid
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |-> (mem_r_n && mem_w_n && (&mem_bw_n) && !rsp_valid && !mem_k));

    assert_read_starts_k_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_r_n) |-> mem_k);

    assert_read_spans_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_r_n && mem_k) |=> (!mem_r_n && !mem_k));

    assert_write_spans_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_w_n && mem_k) |=> (!mem_w_n && !mem_k));

    assert_write_starts_k_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_w_n) |-> mem_k);

    assert_masks_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_w_n |-> (&mem_bw_n));

    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_r_n && mem_w_n && $past(mem_r_n && mem_w_n)) |-> $stable(mem_addr));

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_phase_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (mem_k != $past(mem_k)));

endmodule

bind qdr2_b2_ctrl qdr2_ctrl_checker #(
    .ADDR_W (ADDR_W),
    .LANES  (DATA_W / 9)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_k     (mem_k),
    .mem_r_n   (mem_r_n),
    .mem_w_n   (mem_w_n),
    .mem_addr  (mem_addr),
    .mem_bw_n  (mem_bw_n),
    .rsp_valid (rsp_valid)
);

// File: tb/qdr2_b2_ctrl_bench.sv
module qdr2_b2_ctrl_bench;

    localparam int DW = 36;
    localparam int AW = 10;
    localparam int RL = 2;
    localparam int QD = 4;
    localparam int LN = DW / 9;

    logic          clk, rst_n;
    logic          wr_valid, wr_ready, rd_valid, rd_ready;
    logic [AW-1:0] wr_addr, rd_addr, mem_addr;
    logic [DW-1:0] wr_data0, wr_data1, rsp_data0, rsp_data1, mem_d, mem_q;
    logic [LN-1:0] wr_en0, wr_en1, mem_bw_n;
    logic          rsp_valid, mem_k, mem_r_n, mem_w_n;

    qdr2_b2_ctrl #(.DATA_W(DW), .ADDR_W(AW), .RD_LAT(RL), .QDEPTH(QD)) u_qdr2_b2_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data0(wr_data0), .wr_data1(wr_data1), .wr_en0(wr_en0), .wr_en1(wr_en1),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rsp_valid(rsp_valid), .rsp_data0(rsp_data0), .rsp_data1(rsp_data1),
        .mem_k(mem_k), .mem_r_n(mem_r_n), .mem_w_n(mem_w_n), .mem_addr(mem_addr),
        .mem_bw_n(mem_bw_n), .mem_d(mem_d), .mem_q(mem_q)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] fill_word(input int idx);
        logic [DW-1:0] w;
        for (int i = 0; i < LN; i++) w[i*9 +: 9] = 9'((idx * 7 + i * 13 + 5) & 511);
        return w;
    endfunction

    // Bench shadow (expected) and memory model storage
    logic [DW-1:0] shadow [int];
    logic [DW-1:0] marr   [int];

    function automatic logic [DW-1:0] sh_get(input int idx);
        return shadow.exists(idx) ? shadow[idx] : fill_word(idx);
    endfunction

    function automatic logic [DW-1:0] m_get(input int idx);
        return marr.exists(idx) ? marr[idx] : fill_word(idx);
    endfunction

    typedef struct packed {
        logic [AW-1:0] a;
        logic [DW-1:0] d0;
        logic [DW-1:0] d1;
        logic [LN-1:0] e0;
        logic [LN-1:0] e1;
    } wr_item_t;

    wr_item_t        wexp_q[$];
    logic [AW-1:0]   rexp_q[$];
    logic [2*DW-1:0] rsp_exp_q[$];
    int              rd_t_q[$];
    int              sched_t[$];
    logic [AW-1:0]   sched_a[$];

    bit both_seen     = 0;
    bit wr_block_seen = 0;
    bit rd_block_seen = 0;

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d0,
                            input logic [DW-1:0] d1, input logic [LN-1:0] e0,
                            input logic [LN-1:0] e1);
        wr_item_t it;
        logic [DW-1:0] w;
        forever begin
            @(negedge clk);
            if (wr_ready) break;
        end
        wr_addr = a; wr_data0 = d0; wr_data1 = d1; wr_en0 = e0; wr_en1 = e1;
        wr_valid = 1'b1;
        @(posedge clk);
        #1 wr_valid = 1'b0;
        it.a = a; it.d0 = d0; it.d1 = d1; it.e0 = e0; it.e1 = e1;
        wexp_q.push_back(it);
        w = sh_get(2 * int'(a));
        for (int i = 0; i < LN; i++) if (e0[i]) w[i*9 +: 9] = d0[i*9 +: 9];
        shadow[2 * int'(a)] = w;
        w = sh_get(2 * int'(a) + 1);
        for (int i = 0; i < LN; i++) if (e1[i]) w[i*9 +: 9] = d1[i*9 +: 9];
        shadow[2 * int'(a) + 1] = w;
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        forever begin
            @(negedge clk);
            if (rd_ready) break;
        end
        rd_addr  = a;
        rd_valid = 1'b1;
        @(posedge clk);
        #1 rd_valid = 1'b0;
        rexp_q.push_back(a);
        rsp_exp_q.push_back({sh_get(2 * int'(a)), sh_get(2 * int'(a) + 1)});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Memory model and response monitor
    initial begin
        logic [DW-1:0] wd0, w, e;
        logic [LN-1:0] wb0;
        logic [AW-1:0] ea;
        wr_item_t it;
        bit wpend;
        int t;
        wpend = 0;
        mem_q = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (!wr_ready) wr_block_seen = 1;
                if (!rd_ready) rd_block_seen = 1;
                if (mem_k) begin
                    if (!mem_r_n) begin
                        if (rexp_q.size() == 0) begin
                            check(0, "R2 read strobe with no pending read", 128'(mem_addr), 0);
                        end else begin
                            ea = rexp_q.pop_front();
                            check(mem_addr == ea, "R2 read address in K half (R9 order)", 128'(mem_addr), 128'(ea));
                        end
                        sched_t.push_back(cyc);
                        sched_a.push_back(mem_addr);
                        rd_t_q.push_back(cyc);
                    end
                    if (!mem_w_n) begin
                        wd0 = mem_d;
                        wb0 = mem_bw_n;
                        wpend = 1;
                        if (!mem_r_n) both_seen = 1;
                    end
                end else if (wpend) begin
                    wpend = 0;
                    check(!mem_w_n, "R3 write strobe held in /K half", 128'(mem_w_n), 0);
                    if (wexp_q.size() == 0) begin
                        check(0, "R3 write strobe with no pending write", 128'(mem_addr), 0);
                    end else begin
                        it = wexp_q.pop_front();
                        check(mem_addr == it.a, "R3 write address in /K half (R9 order)", 128'(mem_addr), 128'(it.a));
                        check(wd0 == it.d0, "R4 first beat data", 128'(wd0), 128'(it.d0));
                        check(mem_d == it.d1, "R4 second beat data", 128'(mem_d), 128'(it.d1));
                        check(wb0 == ~it.e0, "R5 first beat masks", 128'(wb0), 128'(~it.e0));
                        check(mem_bw_n == ~it.e1, "R5 second beat masks", 128'(mem_bw_n), 128'(~it.e1));
                    end
                    w = m_get(2 * int'(mem_addr));
                    for (int i = 0; i < LN; i++) if (!wb0[i]) w[i*9 +: 9] = wd0[i*9 +: 9];
                    marr[2 * int'(mem_addr)] = w;
                    w = m_get(2 * int'(mem_addr) + 1);
                    for (int i = 0; i < LN; i++) if (!mem_bw_n[i]) w[i*9 +: 9] = mem_d[i*9 +: 9];
                    marr[2 * int'(mem_addr) + 1] = w;
                end
                if (sched_t.size() > 0) begin
                    if (cyc == sched_t[0] + 2 * RL) begin
                        mem_q = m_get(2 * int'(sched_a[0]));
                    end else if (cyc == sched_t[0] + 2 * RL + 1) begin
                        mem_q = m_get(2 * int'(sched_a[0]) + 1);
                        void'(sched_t.pop_front());
                        void'(sched_a.pop_front());
                    end
                end
                if (rsp_valid) begin
                    if (rsp_exp_q.size() == 0 || rd_t_q.size() == 0) begin
                        check(0, "R8 response with no pending read", 128'(rsp_data0), 0);
                    end else begin
                        e = '0;
                        check({rsp_data0, rsp_data1} == rsp_exp_q[0], "R8 returned pair",
                              128'({rsp_data0, rsp_data1}), 128'(rsp_exp_q[0]));
                        void'(rsp_exp_q.pop_front());
                        t = rd_t_q.pop_front();
                        check(cyc == t + 2 * RL + 2, "R8 response cycle", 128'(cyc), 128'(t + 2 * RL + 2));
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [AW-1:0] held;
        rst_n = 1'b0;
        wr_valid = 1'b0; rd_valid = 1'b0;
        wr_addr = '0; rd_addr = '0; wr_data0 = '0; wr_data1 = '0;
        wr_en0 = '0; wr_en1 = '0;

        // R1 reset state
        repeat (3) begin
            @(negedge clk);
            check(mem_r_n && mem_w_n, "R1 strobes high in reset", 128'({mem_r_n, mem_w_n}), 128'(3));
            check(&mem_bw_n, "R1 masks high in reset", 128'(mem_bw_n), 128'({LN{1'b1}}));
            check(!rsp_valid && !wr_ready && !rd_ready, "R1 no accept or response in reset",
                  128'({rsp_valid, wr_ready, rd_ready}), 0);
            check(!mem_k, "R10 phase low in reset", 128'(mem_k), 0);
        end
        rst_n = 1'b1;

        // R10 phase alternation after release
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(mem_k == ((i % 2) == 0), "R10 phase sequence", 128'(mem_k), 128'((i % 2) == 0));
        end

        // Full write then read back (R2 R3 R4 R8)
        do_write(10'd5, 36'h1_2345_6789, 36'hA_BCDE_F012, 4'hF, 4'hF);
        idle(20);
        do_read(10'd5);
        idle(20);

        // Opposing per-beat masks (R5)
        do_write(10'd5, 36'hF_FFFF_FFFF, 36'h0_0000_0000, 4'b0101, 4'b1010);
        idle(20);
        do_read(10'd5);
        idle(20);

        // Same-cycle read and write (R7)
        both_seen = 0;
        fork
            do_write(10'd9, 36'h5_5555_AAAA, 36'h3_3333_CCCC, 4'hF, 4'hF);
            do_read(10'd5);
        join
        idle(20);
        check(both_seen, "R7 read and write strobes in same cycle", 128'(both_seen), 1);

        // Unwritten location (R8)
        do_read(10'd100);
        idle(20);

        // Back-to-back bursts filling the queues (R9)
        wr_block_seen = 0;
        for (int i = 0; i < 12; i++) begin
            do_write(AW'(20 + i), DW'(36'h0_1000_0000 + i * 36'h111), DW'(36'h9_0000_0000 + i * 36'h7),
                     4'hF, LN'(4'hF - (i % 3)));
        end
        check(wr_block_seen, "R9 write ready low when queue full", 128'(wr_block_seen), 1);
        idle(30);
        rd_block_seen = 0;
        for (int i = 0; i < 12; i++) do_read(AW'(20 + i));
        check(rd_block_seen, "R9 read ready low when queue full", 128'(rd_block_seen), 1);
        idle(40);

        // Idle bus holds address (R6)
        @(negedge clk);
        held = mem_addr;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(mem_r_n && mem_w_n && (&mem_bw_n), "R6 idle strobes and masks",
                  128'({mem_r_n, mem_w_n, mem_bw_n}), 128'({2'b11, {LN{1'b1}}}));
            check(mem_addr == held, "R6 idle address held", 128'(mem_addr), 128'(held));
        end

        for (int i = 0; i < 200; i++) begin
            if (rsp_exp_q.size() == 0 && rexp_q.size() == 0 && wexp_q.size() == 0) break;
            @(negedge clk);
        end
        check(rsp_exp_q.size() == 0 && rexp_q.size() == 0 && wexp_q.size() == 0,
              "R9 every accepted request completed",
              128'(rsp_exp_q.size() + rexp_q.size() + wexp_q.size()), 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule